// File: doc/BRIEF.md
# Signature-Based Commit Conflict Detector

This block keeps a compact summary of everything a transaction has touched. Every load or store address that the core marks as transactional is reduced to its cache line number and hashed into one of two Bloom-filter bit vectors: one for lines read and one for lines written. Nothing is checked while the transaction runs. All conflict detection waits for commit.

When another agent commits, it broadcasts its own write signature. The block intersects that vector with both local signatures in a single step and reports whether any bit survives. A set bit may come from a hash collision, so the flag can be a false positive. A line that really was shared always leaves a surviving bit, so the flag is never a false negative. The local write signature is always visible at an output, so this agent can broadcast it when it commits. A clear command at transaction begin wipes both signatures in one cycle.

Top module: `sig_conflict_detector`

## Requirements
- R1: While and after a synchronous active-low reset, `wsig_o` is all zero, `conflict_o` is 0 and `conflict_valid_o` is 0.
- R2: The line number of an access is `acc_addr_i[31:5]` (32-byte lines). Two byte addresses in the same line set identical signature bits.
- R3: An access sets four bits, one for each hash index j = 0..3. To form index j, rotate the 27-bit line number left by (7*j) mod 27 within 27 bits, zero-pad it to 33 bits, and XOR its three 11-bit chunks. A write access sets those bits in the write signature. A read access sets them in the read signature and leaves `wsig_o` unchanged. Bit i of `wsig_o` is bit i of the write signature.
- R4: Signature bits only accumulate. With no clear, every bit that is set stays set.
- R5: `clear_i` zeroes both signatures in one cycle. If an access arrives in the same cycle as the clear, the signatures hold only that access afterwards.
- R6: A check requested by `chk_valid_i` in cycle t drives `conflict_valid_o` high for exactly cycle t+1. `conflict_o` then equals the OR over all bits of `rmt_wsig_i & (read_sig | write_sig)`. `conflict_valid_o` is low in every cycle that does not follow a check.
- R7: A check sees the signatures as they are after the same cycle's clear and insertion. An access arriving in the same cycle as a check is therefore included in it.
- R8: `conflict_o` keeps its last value until the next check.
- R9: If a remote signature contains the full bit set of any line this transaction read or wrote since its last clear, the check reports a conflict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clear_i | input | 1 | Transaction begin: zero both signatures |
| acc_valid_i | input | 1 | A transactional access is presented |
| acc_is_write_i | input | 1 | 1 = store, 0 = load |
| acc_addr_i | input | 32 | Byte address of the access |
| chk_valid_i | input | 1 | A remote commit is to be checked this cycle |
| rmt_wsig_i | input | 2048 | Remote write signature being committed |
| conflict_o | output | 1 | Result of the latest check |
| conflict_valid_o | output | 1 | One-cycle pulse: `conflict_o` was just updated |
| wsig_o | output | 2048 | Local write signature for broadcast |

## Verification
Signature updates and check results are each one register away from their stimulus. An access, clear or check presented before edge t shows on `wsig_o`, `conflict_o` and `conflict_valid_o` just after edge t, and at no earlier point. The bench drives inputs on the falling edge and compares all three outputs one time unit after every rising edge against a model stepped at the same edge. Every cycle is checked, so a result that arrives early, arrives late or persists too long is caught. Same-cycle clear, insertion and check are driven together, so the ordering of R5 and R7 is checked in the same cycle it matters.

// File: rtl/sigcd_pkg.sv
package sigcd_pkg;
   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/sigcd_hash.sv
// One fixed hash: rotate the line number, then XOR-fold it to an index.
module sigcd_hash #(
   parameter int LINE_W  = 27,
   parameter int IDX_W   = 11,
   parameter int ROT_AMT = 0
) (
   input  logic [LINE_W-1:0] line_i,
   output logic [IDX_W-1:0]  idx_o
);
   localparam int CHUNKS = (LINE_W + IDX_W - 1) / IDX_W;
   localparam int PAD_W  = CHUNKS * IDX_W;

   logic [LINE_W-1:0] rot;
   logic [PAD_W-1:0]  padded;

   generate
      if (ROT_AMT == 0) begin : g_norot
         assign rot = line_i;
      end else begin : g_rot
         assign rot = {line_i[LINE_W-1-ROT_AMT:0], line_i[LINE_W-1 -: ROT_AMT]};
      end
   endgenerate

   assign padded = PAD_W'(rot);

   always_comb begin
      idx_o = '0;
      for (int c = 0; c < CHUNKS; c++) begin
         idx_o = idx_o ^ padded[c*IDX_W +: IDX_W];
      end
   end
endmodule

// File: rtl/sigcd_hash_bank.sv
// All hash functions in parallel, merged into one insertion mask.
module sigcd_hash_bank #(
   parameter int LINE_W   = 27,
   parameter int SIG_BITS = 2048,
   parameter int NUM_HASH = 4,
   parameter int ROT_STEP = 7
) (
   input  logic [LINE_W-1:0]   line_i,
   output logic [SIG_BITS-1:0] mask_o
);
   localparam int IDX_W = $clog2(SIG_BITS);

   logic [IDX_W-1:0] idx [NUM_HASH];

   generate
      for (genvar j = 0; j < NUM_HASH; j++) begin : g_h
         sigcd_hash #(
            .LINE_W  (LINE_W),
            .IDX_W   (IDX_W),
            .ROT_AMT ((j * ROT_STEP) % LINE_W)
         ) u_hash (
            .line_i (line_i),
            .idx_o  (idx[j])
         );
      end
   endgenerate

   always_comb begin
      mask_o = '0;
      for (int j = 0; j < NUM_HASH; j++) begin
         mask_o[idx[j]] = 1'b1;
      end
   end
endmodule

// File: rtl/sigcd_sig_reg.sv
// One signature: clear-then-insert next state, registered.
module sigcd_sig_reg #(
   parameter int SIG_BITS = 2048
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr_i,
   input  logic                ins_i,
   input  logic [SIG_BITS-1:0] mask_i,
   output logic [SIG_BITS-1:0] sig_q_o,
   output logic [SIG_BITS-1:0] sig_nx_o
);
   always_comb begin
      sig_nx_o = clr_i ? '0 : sig_q_o;
      if (ins_i) sig_nx_o = sig_nx_o | mask_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) sig_q_o <= '0;
      else        sig_q_o <= sig_nx_o;
   end
endmodule

// File: rtl/sigcd_intersect.sv
// Any-bit-set of remote & (read | write), reduced per segment then merged.
module sigcd_intersect #(
   parameter int SIG_BITS = 2048,
   parameter int SEG_W    = 64
) (
   input  logic [SIG_BITS-1:0] rmt_i,
   input  logic [SIG_BITS-1:0] rd_i,
   input  logic [SIG_BITS-1:0] wr_i,
   output logic                hit_o
);
   localparam int NSEG = SIG_BITS / SEG_W;

   logic [NSEG-1:0] seg_hit;

   generate
      for (genvar s = 0; s < NSEG; s++) begin : g_seg
         assign seg_hit[s] = |(rmt_i[s*SEG_W +: SEG_W] &
                               (rd_i[s*SEG_W +: SEG_W] | wr_i[s*SEG_W +: SEG_W]));
      end
   endgenerate

   assign hit_o = |seg_hit;
endmodule

// File: rtl/sig_conflict_detector.sv
module sig_conflict_detector #(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 32,
   parameter int SIG_BITS   = 2048,
   parameter int NUM_HASH   = 4,
   parameter int ROT_STEP   = 7,
   parameter int SEG_W      = 64
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clear_i,
   input  logic                acc_valid_i,
   input  logic                acc_is_write_i,
   input  logic [ADDR_W-1:0]   acc_addr_i,
   input  logic                chk_valid_i,
   input  logic [SIG_BITS-1:0] rmt_wsig_i,
   output logic                conflict_o,
   output logic                conflict_valid_o,
   output logic [SIG_BITS-1:0] wsig_o
);
   import sigcd_pkg::*;

   localparam int OFF_W  = $clog2(LINE_BYTES);
   localparam int LINE_W = ADDR_W - OFF_W;

   generate
      if (!is_pow2(SIG_BITS) || SIG_BITS < 64) begin : g_bad_sig
         $error("SIG_BITS must be a power of two of at least 64");
      end
      if (!is_pow2(LINE_BYTES) || OFF_W >= ADDR_W) begin : g_bad_line
         $error("LINE_BYTES must be a power of two smaller than the address space");
      end
      if (NUM_HASH < 1 || NUM_HASH > 8) begin : g_bad_k
         $error("NUM_HASH must be between 1 and 8");
      end
      if (SEG_W < 1 || (SIG_BITS % SEG_W) != 0) begin : g_bad_seg
         $error("SEG_W must divide SIG_BITS");
      end
   endgenerate

   logic [LINE_W-1:0]   line;
   logic [OFF_W-1:0]    unused_off;
   logic [SIG_BITS-1:0] ins_mask;
   logic [SIG_BITS-1:0] rd_sig_q, rd_sig_nx;
   logic [SIG_BITS-1:0] wr_sig_q, wr_sig_nx;
   logic                hit;

   assign line       = acc_addr_i[ADDR_W-1:OFF_W];
   assign unused_off = acc_addr_i[OFF_W-1:0];

   sigcd_hash_bank #(
      .LINE_W   (LINE_W),
      .SIG_BITS (SIG_BITS),
      .NUM_HASH (NUM_HASH),
      .ROT_STEP (ROT_STEP)
   ) u_bank (
      .line_i (line),
      .mask_o (ins_mask)
   );

   sigcd_sig_reg #(.SIG_BITS(SIG_BITS)) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_i    (clear_i),
      .ins_i    (acc_valid_i && !acc_is_write_i),
      .mask_i   (ins_mask),
      .sig_q_o  (rd_sig_q),
      .sig_nx_o (rd_sig_nx)
   );

   sigcd_sig_reg #(.SIG_BITS(SIG_BITS)) u_wr (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_i    (clear_i),
      .ins_i    (acc_valid_i && acc_is_write_i),
      .mask_i   (ins_mask),
      .sig_q_o  (wr_sig_q),
      .sig_nx_o (wr_sig_nx)
   );

   // Check against the post-insertion state so same-cycle accesses count.
   sigcd_intersect #(.SIG_BITS(SIG_BITS), .SEG_W(SEG_W)) u_isect (
      .rmt_i (rmt_wsig_i),
      .rd_i  (rd_sig_nx),
      .wr_i  (wr_sig_nx),
      .hit_o (hit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         conflict_o       <= 1'b0;
         conflict_valid_o <= 1'b0;
      end else begin
         conflict_valid_o <= chk_valid_i;
         if (chk_valid_i) conflict_o <= hit;
      end
   end

   assign wsig_o = wr_sig_q;
endmodule

// File: rtl/sigcd_chk.sv
module sigcd_chk #(
   parameter int SIG_BITS = 2048
) (
   input logic                clk,
   input logic                rst_n,
   input logic                clear_i,
   input logic                acc_valid_i,
   input logic                acc_is_write_i,
   input logic                chk_valid_i,
   input logic [SIG_BITS-1:0] rmt_wsig_i,
   input logic                conflict_o,
   input logic                conflict_valid_o,
   input logic [SIG_BITS-1:0] wsig_o,
   input logic [SIG_BITS-1:0] rd_sig
);
   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |=> (wsig_o == '0 && !conflict_o && !conflict_valid_o));

   // R3
   read_keeps_wsig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid_i && !acc_is_write_i && !clear_i |=> $stable(wsig_o));

   // R4
   bits_accumulate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clear_i |=> ((wsig_o & $past(wsig_o)) == $past(wsig_o)));

   // R5
   clear_zeroes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i && !acc_valid_i |=> (wsig_o == '0 && rd_sig == '0));

   // R6
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chk_valid_i |=> conflict_valid_o);

   // R6
   no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !chk_valid_i |=> !conflict_valid_o);

   // R8
   hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !chk_valid_i |=> $stable(conflict_o));

   // R9
   no_false_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chk_valid_i && !clear_i && (|(rmt_wsig_i & (wsig_o | rd_sig))) |=> conflict_o);
endmodule

bind sig_conflict_detector sigcd_chk #(.SIG_BITS(SIG_BITS)) u_sigcd_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .clear_i          (clear_i),
   .acc_valid_i      (acc_valid_i),
   .acc_is_write_i   (acc_is_write_i),
   .chk_valid_i      (chk_valid_i),
   .rmt_wsig_i       (rmt_wsig_i),
   .conflict_o       (conflict_o),
   .conflict_valid_o (conflict_valid_o),
   .wsig_o           (wsig_o),
   .rd_sig           (rd_sig_q)
);

// File: tb/sig_conflict_detector_tb_top.sv
`timescale 1ns/1ps
module sig_conflict_detector_tb_top;
   localparam int NB = 2048;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          clear_i = 1'b0;
   logic          acc_valid_i = 1'b0;
   logic          acc_is_write_i = 1'b0;
   logic [31:0]   acc_addr_i = '0;
   logic          chk_valid_i = 1'b0;
   logic [NB-1:0] rmt_wsig_i = '0;
   logic          conflict_o;
   logic          conflict_valid_o;
   logic [NB-1:0] wsig_o;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   logic [NB-1:0] m_r = '0;
   logic [NB-1:0] m_w = '0;
   logic          m_conf = 1'b0;
   logic          m_cv = 1'b0;

   always #4 clk = ~clk;

   sig_conflict_detector dut_i (
      .clk              (clk),
      .rst_n            (rst_n),
      .clear_i          (clear_i),
      .acc_valid_i      (acc_valid_i),
      .acc_is_write_i   (acc_is_write_i),
      .acc_addr_i       (acc_addr_i),
      .chk_valid_i      (chk_valid_i),
      .rmt_wsig_i       (rmt_wsig_i),
      .conflict_o       (conflict_o),
      .conflict_valid_o (conflict_valid_o),
      .wsig_o           (wsig_o)
   );

   // Hash index per R3.
   function automatic logic [10:0] hidx(input logic [31:0] a, input int j);
      logic [26:0] ln, rt;
      int r;
      ln = a[31:5];
      r  = (7 * j) % 27;
      rt = (r == 0) ? ln : ((ln << r) | (ln >> (27 - r)));
      return rt[10:0] ^ rt[21:11] ^ {6'b0, rt[26:22]};
   endfunction

   function automatic logic [NB-1:0] hmask(input logic [31:0] a);
      logic [NB-1:0] m;
      m = '0;
      for (int j = 0; j < 4; j++) m[hidx(a, j)] = 1'b1;
      return m;
   endfunction

   task automatic check(input string tag, input bit ok, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   // One cycle of stimulus, model step and full output comparison.
   task automatic cyc(input string tag, input bit clr, input bit av, input bit aw,
                      input logic [31:0] addr, input bit chk, input logic [NB-1:0] rmt);
      logic [NB-1:0] nr, nw, mk;
      @(negedge clk);
      clear_i = clr; acc_valid_i = av; acc_is_write_i = aw;
      acc_addr_i = addr; chk_valid_i = chk; rmt_wsig_i = rmt;
      @(posedge clk);
      #1;
      mk = hmask(addr);
      nr = clr ? '0 : m_r;
      nw = clr ? '0 : m_w;
      if (av && aw)  nw = nw | mk;
      if (av && !aw) nr = nr | mk;
      if (chk) m_conf = |(rmt & (nr | nw));
      m_cv = chk;
      m_r = nr;
      m_w = nw;
      check({tag, " wsig"}, wsig_o == m_w, $countones(wsig_o), $countones(m_w));
      check({tag, " conflict"}, conflict_o == m_conf, conflict_o, m_conf);
      check({tag, " valid"}, conflict_valid_o == m_cv, conflict_valid_o, m_cv);
   endtask

   initial begin
      logic [31:0] pool [16];
      logic [31:0] a_ln, b_ln, c_ln, d_ln, e_ln;
      logic [NB-1:0] rm;
      void'($urandom(32'd4711));
      a_ln = 32'h1000_0040; b_ln = 32'h2345_67A0; c_ln = 32'h0BAD_F00D & ~32'h1F;
      d_ln = 32'h7FFF_FFE0; e_ln = 32'h0000_0020;

      repeat (3) @(posedge clk);
      #1;
      check("R1 wsig", wsig_o == '0, $countones(wsig_o), 0);
      check("R1 conflict", conflict_o == 1'b0, conflict_o, 0);
      check("R1 valid", conflict_valid_o == 1'b0, conflict_valid_o, 0);
      @(negedge clk); rst_n = 1'b1;

      cyc("R3 write", 0, 1, 1, a_ln, 0, '0);
      check("R3 four bits", $countones(wsig_o) <= 4 && $countones(wsig_o) >= 1,
            $countones(wsig_o), 4);
      cyc("R3 read keeps wsig", 0, 1, 0, b_ln, 0, '0);
      cyc("R2 same line", 0, 0, 0, '0, 1, hmask(a_ln + 32'd5));
      check("R2 conflict set", conflict_o == 1'b1, conflict_o, 1);
      cyc("R8 hold", 0, 0, 0, '0, 0, '0);
      cyc("R8 hold2", 0, 0, 0, '0, 0, '1);
      cyc("R9 read set", 0, 0, 0, '0, 1, hmask(b_ln + 32'd31));
      check("R9 read hit", conflict_o == 1'b1, conflict_o, 1);
      cyc("R6 empty remote", 0, 0, 0, '0, 1, '0);
      check("R6 clear result", conflict_o == 1'b0, conflict_o, 0);
      cyc("R5 clear", 1, 0, 0, '0, 0, '0);
      check("R5 zero", wsig_o == '0, $countones(wsig_o), 0);
      cyc("R5 both cleared", 0, 0, 0, '0, 1, hmask(a_ln) | hmask(b_ln));
      cyc("R5 clear with write", 1, 1, 1, c_ln, 0, '0);
      check("R5 only new", wsig_o == hmask(c_ln), $countones(wsig_o), $countones(hmask(c_ln)));
      cyc("R7 same-cycle write", 0, 1, 1, d_ln, 1, hmask(d_ln));
      check("R7 hit", conflict_o == 1'b1, conflict_o, 1);
      cyc("R7 same-cycle read", 1, 1, 0, e_ln, 1, hmask(e_ln));
      check("R7 read hit", conflict_o == 1'b1, conflict_o, 1);
      cyc("R4 accum1", 0, 1, 1, c_ln, 0, '0);
      cyc("R4 accum2", 0, 1, 1, d_ln, 0, '0);
      check("R4 union", wsig_o == (hmask(c_ln) | hmask(d_ln)),
            $countones(wsig_o), $countones(hmask(c_ln) | hmask(d_ln)));

      for (int i = 0; i < 16; i++) pool[i] = {$urandom(), 5'b0} | 32'h0;
      for (int n = 0; n < 3000; n++) begin
         bit clr, av, aw, chk;
         logic [31:0] ad;
         clr = ($urandom_range(0, 99) < 4);
         av  = ($urandom_range(0, 99) < 60);
         aw  = $urandom_range(0, 1);
         chk = ($urandom_range(0, 99) < 30);
         ad  = pool[$urandom_range(0, 15)] | 32'($urandom_range(0, 31));
         rm  = '0;
         for (int k = 0; k < int'($urandom_range(0, 3)); k++)
            rm = rm | hmask(pool[$urandom_range(0, 15)] | 32'($urandom_range(0, 31)));
         cyc("R9 random", clr, av, aw, ad, chk, rm);
      end
      summary();
   end

   initial begin
      repeat (100000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
   end
endmodule